// File: doc/BRIEF.md
# Masked Vector Element Engine

This block runs one vector operation at a time, one element per clock cycle, under a per-element predicate mask. It holds the mask itself (one bit per element slot) and offers three operations: an integer element add whose results go out on an element write port, a signed compare of each element against a scalar that rewrites the mask, and a mask reset that turns every bit on. Source elements are fetched by index: the block presents the element number it needs and reads both source operands in the same cycle, as it would from a vector register file's read ports.

The add runs in one of two modes chosen at start. In the write-gating mode every in-range element occupies an issue slot and the mask only gates the write enable. In the skipping mode a lowest-set-bit search over the remaining work picks the next enabled element, so elements whose mask bit is clear cost no cycles at all. A single-cycle completion pulse follows the last result.

Top module: `masked_vec_exec`

## Requirements
- R1: After reset the mask reads all ones, and busy, done and wr_en are low.
- R2: An add (op code 0) in write-gating mode (dense = 0) takes one issue slot for every element index below the vector length, in increasing order; an element whose mask bit is 1 is written at its own index with (a + b) modulo 2^EW, an element whose mask bit is 0 produces no write.
- R3: An add in skipping mode (dense = 1) writes the same elements with the same data in the same increasing order as R2, but takes issue slots only for in-range elements whose mask bit is 1.
- R4: Elements at or above the vector length are never written nor compared; a vector length above VLMAX acts as VLMAX.
- R5: The mask reset (op code 2) sets every mask bit to 1, including bits above the vector length, and makes no element write.
- R6: The compare (op code 1) sets mask bit i to 1 when element a[i], read as signed, is greater than the signed scalar, and to 0 otherwise, for each i below the vector length; mask bits at or above it keep their value, and no element write occurs.
- R7: done is a one-cycle pulse, high in the cycle after the last write appears; counting the edge that accepts start as edge 0, done becomes high after edge N+1, where N is the number of issue slots (0 for the mask reset and for an empty range).
- R8: start is ignored while busy is high, and start with op code 3 is ignored; neither changes the mask nor produces writes or done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request, sampled when idle |
| op | input | 2 | 0 add, 1 compare to mask, 2 mask reset, 3 ignored |
| dense | input | 1 | 1 selects skipping mode for the add |
| vlen | input | LW | Vector length, clamped to VLMAX |
| scalar | input | EW | Signed scalar for the compare |
| rd_idx | output | IW | Element index being read this cycle |
| rd_a | input | EW | First source element at rd_idx |
| rd_b | input | EW | Second source element at rd_idx |
| mask_o | output | VLMAX | Current mask register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| wr_en | output | 1 | Element write enable |
| wr_idx | output | IW | Element write index |
| wr_data | output | EW | Element write data |

## Verification
The add is tried with a mask from a compare (a scattered pattern), with an all-ones mask, and with a mask whose in-range part has isolated bits; the same pattern is run in both modes, so matching write lists with different latencies separate the mode logic from the gating logic. Lengths of zero, a partial length and one above VLMAX distinguish range limiting from clamping, and sums chosen to overflow show the modular wrap. A compare with a short length after a long one shows that the upper mask bits are left alone, and a start pulse during an add shows that no second command slips in.

// File: rtl/mve_pkg.sv
package mve_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_CMP  = 2'd1,
    OP_CLR  = 2'd2,
    OP_NONE = 2'd3
  } mve_op_e;
endpackage

// File: rtl/mve_lowest.sv
module mve_lowest #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  // isolate lowest set bit
  assign onehot = vec & (~vec + {{(N-1){1'b0}}, 1'b1});

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mve_alu.sv
module mve_alu #(
  parameter int EW = 8
) (
  input  logic [EW-1:0] a,
  input  logic [EW-1:0] b,
  input  logic [EW-1:0] scalar,
  output logic [EW-1:0] sum,
  output logic          gt
);
  function automatic logic [EW-1:0] add_wrap(input logic [EW-1:0] x, input logic [EW-1:0] y);
    return x + y;
  endfunction

  function automatic logic gt_signed(input logic [EW-1:0] x, input logic [EW-1:0] y);
    return $signed(x) > $signed(y);
  endfunction

  assign sum = add_wrap(a, b);
  assign gt  = gt_signed(a, scalar);
endmodule

// File: rtl/mve_mask.sv
module mve_mask #(
  parameter int VLMAX = 16,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_all,
  input  logic             bit_we,
  input  logic [IW-1:0]    bit_idx,
  input  logic             bit_val,
  output logic [VLMAX-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (set_all) mask_q <= '1;
    else if (bit_we)  mask_q[bit_idx] <= bit_val;
  end
endmodule

// File: rtl/masked_vec_exec.sv
module masked_vec_exec
  import mve_pkg::*;
#(
  parameter int VLMAX = 16,
  parameter int EW    = 8,
  localparam int IW   = $clog2(VLMAX),
  localparam int LW   = $clog2(VLMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic             dense,
  input  logic [LW-1:0]    vlen,
  input  logic [EW-1:0]    scalar,
  output logic [IW-1:0]    rd_idx,
  input  logic [EW-1:0]    rd_a,
  input  logic [EW-1:0]    rd_b,
  output logic [VLMAX-1:0] mask_o,
  output logic             busy,
  output logic             done,
  output logic             wr_en,
  output logic [IW-1:0]    wr_idx,
  output logic [EW-1:0]    wr_data
);
  // captured command
  logic             run_q, fin_q, done_q;
  mve_op_e          op_q;
  logic             dense_q;
  logic [LW-1:0]    vl_q;
  logic [EW-1:0]    scalar_q;
  logic [VLMAX-1:0] rem_q;

  // named events
  logic             accept;
  logic             issue;
  logic             last;
  logic [IW-1:0]    issue_idx;
  logic [VLMAX-1:0] issue_oh;
  logic [LW-1:0]    vl_eff;
  logic [VLMAX-1:0] len_mask;
  logic [VLMAX-1:0] init_rem;
  logic [EW-1:0]    elem_sum;
  logic             elem_gt;
  logic             mask_set_all;
  logic             mask_bit_we;

  assign busy   = run_q | fin_q;
  assign accept = start && !busy && (mve_op_e'(op) != OP_NONE);
  assign vl_eff = (vlen > LW'(VLMAX)) ? LW'(VLMAX) : vlen;

  genvar g;
  generate
    for (g = 0; g < VLMAX; g++) begin : g_len
      assign len_mask[g] = (LW'(g) < vl_eff);
    end
  endgenerate

  always_comb begin
    case (mve_op_e'(op))
      OP_ADD:  init_rem = dense ? (mask_o & len_mask) : len_mask;
      OP_CMP:  init_rem = len_mask;
      default: init_rem = '0;
    endcase
  end

  mve_lowest #(.N(VLMAX), .IW(IW)) u_scan (
    .vec    (rem_q),
    .idx    (issue_idx),
    .onehot (issue_oh)
  );

  assign issue  = run_q;
  assign last   = (rem_q & ~issue_oh) == '0;
  assign rd_idx = issue_idx;

  mve_alu #(.EW(EW)) u_alu (
    .a      (rd_a),
    .b      (rd_b),
    .scalar (scalar_q),
    .sum    (elem_sum),
    .gt     (elem_gt)
  );

  assign mask_set_all = accept && (mve_op_e'(op) == OP_CLR);
  assign mask_bit_we  = issue && (op_q == OP_CMP);

  mve_mask #(.VLMAX(VLMAX), .IW(IW)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_all (mask_set_all),
    .bit_we  (mask_bit_we),
    .bit_idx (issue_idx),
    .bit_val (elem_gt),
    .mask_q  (mask_o)
  );

  // sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      fin_q    <= 1'b0;
      done_q   <= 1'b0;
      op_q     <= OP_NONE;
      dense_q  <= 1'b0;
      vl_q     <= '0;
      scalar_q <= '0;
      rem_q    <= '0;
    end else begin
      done_q <= fin_q;
      fin_q  <= 1'b0;
      if (accept) begin
        op_q     <= mve_op_e'(op);
        dense_q  <= dense;
        vl_q     <= vl_eff;
        scalar_q <= scalar;
        rem_q    <= init_rem;
        run_q    <= (init_rem != '0);
        fin_q    <= (init_rem == '0);
      end else if (issue) begin
        rem_q <= rem_q & ~issue_oh;
        if (last) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  // element write port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= issue && (op_q == OP_ADD) && mask_o[issue_idx];
      wr_idx  <= issue_idx;
      wr_data <= elem_sum;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/mve_chk.sv
module mve_chk
  import mve_pkg::*;
#(
  parameter int VLMAX = 16,
  parameter int IW    = 4,
  parameter int LW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             wr_en,
  input logic [IW-1:0]    wr_idx,
  input logic [VLMAX-1:0] mask_o,
  input logic [LW-1:0]    vl_q,
  input logic             issue,
  input logic [IW-1:0]    issue_idx,
  input logic             dense_q,
  input mve_op_e          op_q
);
  // R4
  wr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (LW'(wr_idx) < vl_q));

  // R2
  wr_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> mask_o[wr_idx]);

  // R3
  dense_skips_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && dense_q && op_q == OP_ADD) |-> mask_o[issue_idx]);

  // R6
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && op_q == OP_CMP) |=> !wr_en);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op_q) && $stable(vl_q)));
endmodule

bind masked_vec_exec mve_chk #(.VLMAX(VLMAX), .IW(IW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .mask_o    (mask_o),
  .vl_q      (vl_q),
  .issue     (issue),
  .issue_idx (issue_idx),
  .dense_q   (dense_q),
  .op_q      (op_q)
);

// File: tb/test_masked_vec_exec.sv
module test_masked_vec_exec;
  localparam int CLK_PERIOD = 10;
  localparam int VLMAX = 16;
  localparam int EW    = 8;
  localparam int IW    = 4;
  localparam int LW    = 5;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [1:0]       op;
  logic             dense;
  logic [LW-1:0]    vlen;
  logic [EW-1:0]    scalar;
  logic [IW-1:0]    rd_idx;
  logic [EW-1:0]    rd_a, rd_b;
  logic [VLMAX-1:0] mask_o;
  logic             busy, done, wr_en;
  logic [IW-1:0]    wr_idx;
  logic [EW-1:0]    wr_data;

  logic [EW-1:0]    va [VLMAX];
  logic [EW-1:0]    vb [VLMAX];
  logic [VLMAX-1:0] exp_mask;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign rd_a = va[rd_idx];
  assign rd_b = vb[rd_idx];

  masked_vec_exec #(.VLMAX(VLMAX), .EW(EW)) i_masked_vec_exec (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dense(dense),
    .vlen(vlen), .scalar(scalar), .rd_idx(rd_idx), .rd_a(rd_a), .rd_b(rd_b),
    .mask_o(mask_o), .busy(busy), .done(done), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // op: 0 add, 1 compare, 2 mask reset; inject pulses a mask reset mid-run
  task automatic run_op(input logic [1:0] o, input logic d, input int vl,
                        input logic [EW-1:0] sc, input bit inject, input string req);
    int vle, n_slots, n_exp, n_got, edges;
    int  e_idx [VLMAX];
    logic [EW-1:0] e_dat [VLMAX];
    int  g_idx [VLMAX];
    logic [EW-1:0] g_dat [VLMAX];
    vle = (vl > VLMAX) ? VLMAX : vl;
    n_slots = 0; n_exp = 0; n_got = 0; edges = 0;
    if (o == 2'd0) begin
      for (int i = 0; i < vle; i++) begin
        if (exp_mask[i]) begin
          e_idx[n_exp] = i;
          e_dat[n_exp] = va[i] + vb[i];
          n_exp++;
        end
      end
      n_slots = d ? n_exp : vle;
    end else if (o == 2'd1) begin
      for (int i = 0; i < vle; i++) exp_mask[i] = $signed(va[i]) > $signed(sc);
      n_slots = vle;
    end else begin
      exp_mask = '1;
      n_slots = 0;
    end
    @(negedge clk);
    start = 1'b1; op = o; dense = d; vlen = LW'(vl); scalar = sc;
    while (1) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      start = 1'b0;
      if (inject && edges == 3) begin
        start = 1'b1; op = 2'd2;
      end
      if (wr_en) begin
        if (n_got < VLMAX) begin
          g_idx[n_got] = int'(wr_idx);
          g_dat[n_got] = wr_data;
        end
        n_got++;
      end
      if (done) break;
      if (edges > 200) begin
        check(1'b0, {req, " watchdog"}, edges, n_slots + 2);
        break;
      end
    end
    start = 1'b0;
    check(edges == n_slots + 2, {req, " R7 latency"}, edges, n_slots + 2);
    check(n_got == n_exp, {req, " write count"}, n_got, n_exp);
    for (int k = 0; k < n_exp && k < n_got; k++) begin
      check(g_idx[k] == e_idx[k], {req, " write index"}, g_idx[k], e_idx[k]);
      check(g_dat[k] == e_dat[k], {req, " write data"}, g_dat[k], e_dat[k]);
    end
    check(mask_o == exp_mask, {req, " mask"}, mask_o, exp_mask);
    @(negedge clk);
    check(!done, {req, " R7 done pulse"}, done, 0);
  endtask

  task automatic t_reset();
    check(mask_o == '1, "R1 mask", mask_o, 16'hFFFF);
    check(!busy, "R1 busy", busy, 0);
    check(!done, "R1 done", done, 0);
    check(!wr_en, "R1 wr_en", wr_en, 0);
  endtask

  task automatic t_bad_op();
    logic [VLMAX-1:0] m0;
    bit seen;
    m0 = mask_o;
    seen = 1'b0;
    @(negedge clk);
    start = 1'b1; op = 2'd3; vlen = 5'd16; dense = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      if (busy || done || wr_en) seen = 1'b1;
      @(negedge clk);
    end
    check(!seen, "R8 op 3 ignored", seen, 0);
    check(mask_o == m0, "R8 op 3 mask", mask_o, m0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < VLMAX; i++) begin
      va[i] = EW'(i * 37 + 5);
      vb[i] = EW'(i * 91 + 200);
    end
    rst_n = 1'b0; start = 1'b0; op = 2'd0; dense = 1'b0; vlen = '0; scalar = '0;
    exp_mask = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_op(2'd0, 1'b1, 16, 8'd0, 1'b0, "R3 dense all ones");
    run_op(2'd1, 1'b0, 16, 8'd0, 1'b0, "R6 compare full");
    run_op(2'd0, 1'b0, 16, 8'd0, 1'b0, "R2 simple scattered");
    run_op(2'd0, 1'b1, 16, 8'd0, 1'b0, "R3 dense scattered");
    run_op(2'd0, 1'b1, 10, 8'd0, 1'b0, "R4 dense partial");
    run_op(2'd0, 1'b0, 20, 8'd0, 1'b0, "R4 simple clamp");
    run_op(2'd1, 1'b0, 5, 8'hFD, 1'b0, "R6 compare short");
    run_op(2'd0, 1'b1, 0, 8'd0, 1'b0, "R7 empty dense");
    run_op(2'd0, 1'b0, 0, 8'd0, 1'b0, "R7 empty simple");
    run_op(2'd0, 1'b0, 16, 8'd0, 1'b1, "R8 start while busy");
    t_bad_op();
    run_op(2'd2, 1'b0, 3, 8'd0, 1'b0, "R5 mask reset");
    va[2] = 8'h7F; vb[2] = 8'h90;
    run_op(2'd0, 1'b0, 4, 8'd0, 1'b0, "R2 wrap add");
    run_op(2'd1, 1'b0, 16, 8'h40, 1'b0, "R6 compare high");
    run_op(2'd0, 1'b1, 16, 8'd0, 1'b0, "R3 dense sparse");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule